// File: doc/BRIEF.md
# Double-Buffered Quarter-Step PWM Generator

This block produces a pulse-width modulated output from an 8-bit period counter. Below the counter sits a 2-bit sub-count, and together they form a 10-bit time base. The duty value is therefore resolved to one quarter of a counter step. A prescaler sets the rate of the time base. It advances once every 1, 4 or 16 input clocks, and the 8-bit counter steps once every four time-base ticks.

Software may change the period value or either half of the 10-bit duty value at any moment. The duty halves are an 8-bit upper field and a 2-bit lower field, and each has its own write strobe. The comparison never uses the written duty value directly. It uses a shadow copy, and that copy is reloaded only when a period ends. At that boundary the counter returns to zero and the output goes high, unless the new duty value is zero. The output goes low again when the time base reaches the shadow duty value. A one-clock strobe marks the first clock of every new period.

Top module: `dbl_pwm`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, `pwm_out` and `match_stb` are 0. Reset also clears the counter, the sub-count, the duty buffer and the shadow copy.
- R2: One period lasts (period + 1) × 4 × ratio clocks. The ratio is set by `pre_sel`: 0 selects 1, 1 selects 4, and 2 or 3 select 16.
- R3: The duty value D is {`duty_hi`, `duty_lo`}, with `duty_hi` in bits 9:2 and `duty_lo` in bits 1:0. The output is high for D × ratio clocks at the start of each period.
- R4: The two duty fields are written independently. Writing one field leaves the other field unchanged.
- R5: The shadow duty copy changes only at a period rollover. A duty write in the middle of a period does not alter that period's pulse, and it takes effect from the next period.
- R6: If a duty write lands on the same clock edge as a rollover, the shadow receives the value held before the write. The written value is used from the following period.
- R7: A shadow duty value of 0 keeps `pwm_out` low for the whole period.
- R8: A duty value of 4 × (period + 1) or more keeps `pwm_out` high for the whole period.
- R9: `match_stb` is high for exactly one clock, which is the first clock of each new period. `pwm_out` rises only in a clock where `match_stb` is high.
- R10: While `en` is low, `pwm_out` and `match_stb` stay low and the counters are held at zero. After `en` rises, the first rollover comes after one full period. `pwm_out` stays low until that rollover, and the following period uses the shadow value loaded there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears counters and output |
| pre_sel | input | 2 | Prescale select (0: ÷1, 1: ÷4, 2/3: ÷16) |
| period | input | CNT_W (8) | Period value compared with the counter |
| duty_hi_we | input | 1 | Write strobe for the upper duty field |
| duty_hi | input | CNT_W (8) | Upper duty field, D[9:2] |
| duty_lo_we | input | 1 | Write strobe for the lower duty field |
| duty_lo | input | SUB_W (2) | Lower duty field, D[1:0] |
| pwm_out | output | 1 | PWM output |
| match_stb | output | 1 | One-clock strobe at the start of each period |

## Verification
The two functions that can coincide are a duty write and a period rollover. The bench first measures one period so it knows where the period edges fall. It then raises both write strobes so that they are sampled on the exact edge where the next rollover happens, and it confirms that `match_stb` appears in the clock that follows. That period must still show the old pulse width, and the period after it must show the new one. A second write, placed in the first clock of a period, checks that a mid-period change leaves the current pulse untouched.

// File: rtl/dbl_pwm_pkg.sv
package dbl_pwm_pkg;

   typedef enum logic [1:0] {
      PS_DIV1   = 2'd0,
      PS_DIV4   = 2'd1,
      PS_DIV16  = 2'd2,
      PS_DIV16B = 2'd3
   } ps_sel_e;

endpackage

// File: rtl/dbl_pwm_presc.sv
module dbl_pwm_presc #(
   parameter int unsigned MID_LOG2 = 2,
   parameter int unsigned HI_LOG2  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] sel,
   output logic       step
);
   import dbl_pwm_pkg::*;

   localparam int unsigned PC_W = (HI_LOG2 > 0) ? HI_LOG2 : 1;

   if (MID_LOG2 > HI_LOG2) begin : g_bad_ratio
      $error("dbl_pwm_presc: MID_LOG2 must not exceed HI_LOG2");
   end

   if (HI_LOG2 == 0) begin : g_direct
      // every clock is a time-base tick
      assign step = en;
   end else begin : g_count
      logic [PC_W-1:0] pc_q;
      logic [PC_W-1:0] last;

      always_comb begin
         case (ps_sel_e'(sel))
            PS_DIV1: last = '0;
            PS_DIV4: last = PC_W'((1 << MID_LOG2) - 1);
            default: last = '1;
         endcase
      end

      // ">=" keeps a ratio change mid-count from stalling the counter
      assign step = en && (pc_q >= last);

      always_ff @(posedge clk) begin
         if (!rst_n)
            pc_q <= '0;
         else if (!en || step)
            pc_q <= '0;
         else
            pc_q <= pc_q + 1'b1;
      end
   end

endmodule

// File: rtl/dbl_pwm_tbase.sv
module dbl_pwm_tbase #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SUB_W = 2,
   localparam int unsigned TB_W = CNT_W + SUB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic [CNT_W-1:0] period,
   output logic [TB_W-1:0]  tb_nxt,
   output logic             roll,
   output logic             match_stb
);
   logic [CNT_W-1:0] cnt_q;
   logic [SUB_W-1:0] sub_q;
   logic [TB_W-1:0]  tb;

   assign tb     = {cnt_q, sub_q};
   assign tb_nxt = tb + 1'b1;
   assign roll   = step && (&sub_q) && (cnt_q == period);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         sub_q     <= '0;
         match_stb <= 1'b0;
      end else if (!en) begin
         cnt_q     <= '0;
         sub_q     <= '0;
         match_stb <= 1'b0;
      end else begin
         match_stb <= roll;
         if (roll) begin
            cnt_q <= '0;
            sub_q <= '0;
         end else if (step) begin
            {cnt_q, sub_q} <= tb_nxt;
         end
      end
   end

endmodule

// File: rtl/dbl_pwm_duty.sv
module dbl_pwm_duty #(
   parameter int unsigned HI_W = 8,
   parameter int unsigned LO_W = 2,
   localparam int unsigned D_W = HI_W + LO_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hi_we,
   input  logic [HI_W-1:0] hi_d,
   input  logic            lo_we,
   input  logic [LO_W-1:0] lo_d,
   input  logic            roll,
   output logic [D_W-1:0]  shadow,
   output logic            load_nz
);
   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;

   // buffer accepts writes at any time
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (hi_we) hi_q <= hi_d;
         if (lo_we) lo_q <= lo_d;
      end
   end

   // shadow takes the registered buffer, so a same-edge write waits a period
   always_ff @(posedge clk) begin
      if (!rst_n)
         shadow <= '0;
      else if (roll)
         shadow <= {hi_q, lo_q};
   end

   assign load_nz = |{hi_q, lo_q};

endmodule

// File: rtl/dbl_pwm_outstage.sv
module dbl_pwm_outstage #(
   parameter int unsigned TB_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            step,
   input  logic            roll,
   input  logic            load_nz,
   input  logic [TB_W-1:0] tb_nxt,
   input  logic [TB_W-1:0] shadow,
   output logic            pwm_out
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         pwm_out <= 1'b0;
      else if (!en)
         pwm_out <= 1'b0;
      else if (roll)
         pwm_out <= load_nz;
      else if (step && (tb_nxt == shadow))
         pwm_out <= 1'b0;
   end

endmodule

// File: rtl/dbl_pwm.sv
module dbl_pwm #(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned SUB_W        = 2,
   parameter int unsigned PRE_MID_LOG2 = 2,
   parameter int unsigned PRE_HI_LOG2  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       pre_sel,
   input  logic [CNT_W-1:0] period,
   input  logic             duty_hi_we,
   input  logic [CNT_W-1:0] duty_hi,
   input  logic             duty_lo_we,
   input  logic [SUB_W-1:0] duty_lo,
   output logic             pwm_out,
   output logic             match_stb
);
   localparam int unsigned TB_W = CNT_W + SUB_W;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("dbl_pwm: CNT_W must be at least 2");
   end
   if (SUB_W < 1) begin : g_bad_sub
      $error("dbl_pwm: SUB_W must be at least 1");
   end

   logic            step;
   logic            roll;
   logic [TB_W-1:0] tb_nxt;
   logic [TB_W-1:0] shadow_q;
   logic            load_nz;

   dbl_pwm_presc #(
      .MID_LOG2 (PRE_MID_LOG2),
      .HI_LOG2  (PRE_HI_LOG2)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .sel   (pre_sel),
      .step  (step)
   );

   dbl_pwm_tbase #(
      .CNT_W (CNT_W),
      .SUB_W (SUB_W)
   ) u_tbase (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .step      (step),
      .period    (period),
      .tb_nxt    (tb_nxt),
      .roll      (roll),
      .match_stb (match_stb)
   );

   dbl_pwm_duty #(
      .HI_W (CNT_W),
      .LO_W (SUB_W)
   ) u_duty (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_we   (duty_hi_we),
      .hi_d    (duty_hi),
      .lo_we   (duty_lo_we),
      .lo_d    (duty_lo),
      .roll    (roll),
      .shadow  (shadow_q),
      .load_nz (load_nz)
   );

   dbl_pwm_outstage #(
      .TB_W (TB_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .step    (step),
      .roll    (roll),
      .load_nz (load_nz),
      .tb_nxt  (tb_nxt),
      .shadow  (shadow_q),
      .pwm_out (pwm_out)
   );

endmodule

// File: rtl/dbl_pwm_chk.sv
module dbl_pwm_chk #(
   parameter int unsigned TB_W = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            pwm_out,
   input logic            match_stb,
   input logic [TB_W-1:0] shadow
);
   // R9: strobe lasts a single clock
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      match_stb |=> !match_stb);

   // R9: output only rises at the start of a period
   a_r9_rise_at_roll: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> match_stb);

   // R7: zero duty loaded at rollover keeps the output low
   a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (match_stb && (shadow == '0)) |-> !pwm_out);

   // R5: shadow copy moves only at rollover
   a_r5_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !match_stb |-> $stable(shadow));

   // R10: disabled block is quiet on the next clock
   a_r10_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm_out && !match_stb));

endmodule

bind dbl_pwm dbl_pwm_chk #(.TB_W(CNT_W + SUB_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .pwm_out   (pwm_out),
   .match_stb (match_stb),
   .shadow    (shadow_q)
);

// File: tb/tb_dbl_pwm.sv
`timescale 1ns/1ps
module tb_dbl_pwm;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [1:0] pre_sel = 2'd0;
   logic [7:0] period = 8'd0;
   logic       duty_hi_we = 1'b0;
   logic [7:0] duty_hi = 8'd0;
   logic       duty_lo_we = 1'b0;
   logic [1:0] duty_lo = 2'd0;
   logic       pwm_out;
   logic       match_stb;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dbl_pwm dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .pre_sel    (pre_sel),
      .period     (period),
      .duty_hi_we (duty_hi_we),
      .duty_hi    (duty_hi),
      .duty_lo_we (duty_lo_we),
      .duty_lo    (duty_lo),
      .pwm_out    (pwm_out),
      .match_stb  (match_stb)
   );

   typedef struct packed {
      logic [1:0]  ps;
      logic [7:0]  p;
      logic [9:0]  d;
      int unsigned per;
      int unsigned hi;
   } vec_t;

   // pre_sel, period, duty -> expected period clocks, high clocks
   localparam vec_t VECS [9] = '{
      '{2'd0, 8'd9,   10'd17,   40, 17},
      '{2'd1, 8'd4,   10'd7,    80, 28},
      '{2'd2, 8'd2,   10'd5,   192, 80},
      '{2'd0, 8'd3,   10'd0,    16,  0},
      '{2'd0, 8'd3,   10'd16,   16, 16},
      '{2'd1, 8'd3,   10'd1023, 64, 64},
      '{2'd0, 8'd0,   10'd3,     4,  3},
      '{2'd0, 8'd255, 10'd1,  1024,  1},
      '{2'd3, 8'd1,   10'd6,   128, 96}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put_duty(input logic [9:0] d, input logic wh, input logic wl);
      duty_hi    = d[9:2];
      duty_lo    = d[1:0];
      duty_hi_we = wh;
      duty_lo_we = wl;
   endtask

   task automatic drop_we();
      duty_hi_we = 1'b0;
      duty_lo_we = 1'b0;
   endtask

   // from a negedge: wait for a strobe, then count one full period
   task automatic measure(output int per, output int hi);
      per = 0;
      hi  = 0;
      while (match_stb !== 1'b1) @(negedge clk);
      do begin
         per++;
         if (pwm_out) hi++;
         @(negedge clk);
      end while (match_stb !== 1'b1);
   endtask

   // apply settings at a negedge, skip a rollover that shares the write edge
   task automatic load_cfg(input logic [1:0] ps, input logic [7:0] p, input logic [9:0] d);
      pre_sel = ps;
      period  = p;
      put_duty(d, 1'b1, 1'b1);
      @(negedge clk);
      drop_we();
      if (match_stb) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int per;
      int hi;
      int cnt;
      int ok;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 pwm_out in reset", pwm_out, 0);
      chk("R1 match_stb in reset", match_stb, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 pwm_out after release, disabled", pwm_out, 0);
      chk("R1 match_stb after release, disabled", match_stb, 0);

      en = 1'b1;
      foreach (VECS[i]) begin
         load_cfg(VECS[i].ps, VECS[i].p, VECS[i].d);
         measure(per, hi);
         chk($sformatf("R2 period vec%0d", i), per, int'(VECS[i].per));
         if (VECS[i].d == 10'd0)
            chk($sformatf("R7 high time vec%0d", i), hi, int'(VECS[i].hi));
         else if (int'(VECS[i].d) >= 4 * (int'(VECS[i].p) + 1))
            chk($sformatf("R8 high time vec%0d", i), hi, int'(VECS[i].hi));
         else
            chk($sformatf("R3 high time vec%0d", i), hi, int'(VECS[i].hi));
      end

      // R6: write on the rollover edge
      load_cfg(2'd0, 8'd4, 10'd10);
      measure(per, hi);
      chk("R3 base period high", hi, 10);
      repeat (19) @(negedge clk);
      put_duty(10'd6, 1'b1, 1'b1);
      @(negedge clk);
      chk("R9 strobe at period boundary", match_stb, 1);
      drop_we();
      measure(per, hi);
      chk("R6 colliding write keeps old duty", hi, 10);
      chk("R9 period after collision", per, 20);
      measure(per, hi);
      chk("R6 new duty next period", hi, 6);

      // R5: write during a running period
      put_duty(10'd14, 1'b1, 1'b1);
      per = 0;
      hi  = 0;
      do begin
         per++;
         if (pwm_out) hi++;
         @(negedge clk);
         drop_we();
      end while (match_stb !== 1'b1);
      chk("R5 mid-period write leaves current pulse", hi, 6);
      measure(per, hi);
      chk("R5 mid-period write used next period", hi, 14);

      // R4: lower field alone, then upper field alone
      duty_hi    = 8'hFF;
      duty_lo    = 2'd1;
      duty_lo_we = 1'b1;
      @(negedge clk);
      drop_we();
      if (match_stb) @(negedge clk);
      measure(per, hi);
      chk("R4 lower field write only", hi, 13);
      duty_hi    = 8'd2;
      duty_lo    = 2'd3;
      duty_hi_we = 1'b1;
      @(negedge clk);
      drop_we();
      if (match_stb) @(negedge clk);
      measure(per, hi);
      chk("R4 upper field write only", hi, 9);

      // R10: disable and re-enable
      en = 1'b0;
      @(negedge clk);
      ok = 1;
      repeat (40) begin
         if (pwm_out || match_stb) ok = 0;
         @(negedge clk);
      end
      chk("R10 quiet while disabled", ok, 1);
      en  = 1'b1;
      cnt = 0;
      ok  = 1;
      do begin
         @(negedge clk);
         cnt++;
         if (pwm_out && !match_stb) ok = 0;
      end while (match_stb !== 1'b1);
      chk("R10 first rollover after full period", cnt, 20);
      chk("R10 output low before first rollover", ok, 1);
      measure(per, hi);
      chk("R10 first full period uses loaded shadow", hi, 9);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule